// File: doc/BRIEF.md
# Serial Sample Capture Port

This block collects audio sample bits that an analog-to-digital converter sends one at a time, and hands the finished sample to a processor that polls for it. The serial bits enter a shift chain built from cascaded byte-wide stages. A strobe at the end of each conversion frame copies the chain into a separate holding register. The processor reads the holding register through a gated data port. It learns that a new sample is waiting from a status word that it polls, because no interrupt is raised.

The serial data, bit clock and frame strobe come from outside the system clock domain. Each one passes through the same synchroniser depth, so a data bit and the bit-clock edge that qualifies it stay aligned. The processor read strobe is synchronous to the system clock and lasts one cycle for each read. When a second frame completes before the first has been read, the new sample replaces the old one and a sticky overrun bit records the lost sample.

Top module: `adc_capture_port`

## Requirements
- R1: After reset the status word is all zero, and a read returns 16'h0000.
- R2: With the default MSB-first order, one bit is taken on each rising edge of the bit clock. The first bit of a frame ends up in bit 15 of the sample.
- R3: A rising edge of the frame strobe copies the shift chain into the holding register.
- R4: A transfer sets status bit 0 (ready).
- R5: While the read strobe is high, the data port drives the held sample. While it is low, the data port drives zero.
- R6: A read with no transfer in the same cycle clears status bit 0 and status bit 1.
- R7: A transfer while ready is set, with no read in that cycle, replaces the held sample, keeps ready at 1 and sets status bit 1 (overrun).
- R8: A read made while a new sample is still being shifted in returns the previously held sample unchanged.
- R9: Only rising edges of the bit clock shift the chain. Holding the bit clock high, or changing the data line while it is high, takes no extra bits.
- R10: When a read and a transfer fall in the same cycle, the new sample is held, ready stays 1 and overrun stays 0.
- R11: If more than 16 bits arrive in a frame, only the last 16 are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data_i | input | 1 | Serial sample data from the converter |
| bit_clk_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| frame_i | input | 1 | End-of-conversion strobe; its rising edge triggers the transfer |
| rd_i | input | 1 | Processor read strobe for the sample slot, one cycle per read |
| rdata_o | output | 16 | Held sample while rd_i is high, zero otherwise |
| status_o | output | 8 | Polled status: bit 0 ready, bit 1 overrun, other bits zero |

## Verification
The bench drives a bit clock that stays high for a long time while the data line toggles. A design that shifted on the clock level would collect a burst of extra bits and corrupt the word. It reads in the middle of a frame, where a design that gave the chain the same register as the holding word would return half-shifted data. It also lines up a read exactly on the transfer cycle: a design that let the read win would clear ready and lose the new sample, and a design that checked ready without the read would report a false overrun. Frames longer than 16 bits, and two frames with no read between them, show whether old bits and lost samples are handled as the requirements state.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
   localparam int unsigned STAT_READY_BIT = 0;
   localparam int unsigned STAT_OVR_BIT   = 1;
   localparam int unsigned STAT_MIN_W     = 2;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("level_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sample_shifter.sv
module sample_shifter #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned STAGE_W   = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_lvl,
   input  logic              data_lvl,
   output logic [WORD_W-1:0] word_o
);
   localparam int unsigned NSTG = WORD_W / STAGE_W;

   if (STAGE_W < 2 || (WORD_W % STAGE_W) != 0) begin : g_bad_split
      $error("sample_shifter: WORD_W must be a multiple of STAGE_W >= 2");
   end

   logic bclk_prev_q;
   logic shift_en;

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_prev_q <= 1'b0;
      else        bclk_prev_q <= bclk_lvl;
   end

   assign shift_en = bclk_lvl & ~bclk_prev_q;

   for (genvar g = 0; g < NSTG; g++) begin : stg
      logic [STAGE_W-1:0] st_q;
      logic               sin;

      if (MSB_FIRST) begin : g_left
         if (g == 0) begin : g_head
            assign sin = data_lvl;
         end else begin : g_link
            assign sin = stg[g-1].st_q[STAGE_W-1];
         end
      end else begin : g_right
         if (g == NSTG-1) begin : g_head
            assign sin = data_lvl;
         end else begin : g_link
            assign sin = stg[g+1].st_q[0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)        st_q <= '0;
         else if (shift_en) st_q <= MSB_FIRST ? {st_q[STAGE_W-2:0], sin}
                                              : {sin, st_q[STAGE_W-1:1]};
      end

      assign word_o[g*STAGE_W +: STAGE_W] = st_q;
   end

   // R9: without a rising bit-clock edge the chain holds
   a_r9_no_edge_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      !(bclk_lvl && !bclk_prev_q) |=> $stable(word_o));

   if (MSB_FIRST) begin : g_chk_msb
      // R2: the new bit enters at the low end and older bits move up
      a_r2_bit_enters_low: assert property (@(posedge clk) disable iff (!rst_n)
         (bclk_lvl && !bclk_prev_q) |=>
            (word_o == {$past(word_o[WORD_W-2:0]), $past(data_lvl)}));
   end
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_lvl,
   input  logic              rd_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] hold_o,
   output logic              ready_o,
   output logic              ovr_o
);
   logic frame_prev_q;
   logic xfer;

   always_ff @(posedge clk) begin
      if (!rst_n) frame_prev_q <= 1'b0;
      else        frame_prev_q <= frame_lvl;
   end

   assign xfer = frame_lvl & ~frame_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_o  <= '0;
         ready_o <= 1'b0;
         ovr_o   <= 1'b0;
      end else begin
         if (xfer) hold_o <= word_i;
         ready_o <= xfer | (ready_o & ~rd_i);
         ovr_o   <= ~rd_i & (ovr_o | (xfer & ready_o));
      end
   end

   // R3: the transfer captures the chain
   a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (hold_o == $past(word_i)));
   // R8: with no transfer the held sample does not move
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(hold_o));
   // R4: ready follows every transfer
   a_r4_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> ready_o);
   // R6: a read alone clears both flags
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !xfer) |=> (!ready_o && !ovr_o));
   // R7: unread sample replaced -> overrun
   a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && ready_o && !rd_i) |=> ovr_o);
   // R10: a read on the transfer cycle never raises overrun
   a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && rd_i) |=> (ready_o && !ovr_o));
endmodule

// File: rtl/adc_capture_port.sv
module adc_capture_port
   import adc_cap_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned STAGE_W     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STAT_W      = 8,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_data_i,
   input  logic              bit_clk_i,
   input  logic              frame_i,
   input  logic              rd_i,
   output logic [WORD_W-1:0] rdata_o,
   output logic [STAT_W-1:0] status_o
);
   localparam int unsigned NSYNC = 3;

   if (STAT_W < STAT_MIN_W) begin : g_bad_stat
      $error("adc_capture_port: STAT_W too small for ready and overrun bits");
   end

   logic [NSYNC-1:0] raw_in;
   logic [NSYNC-1:0] lvl;
   logic [WORD_W-1:0] chain_word;
   logic [WORD_W-1:0] hold_word;
   logic              ready;
   logic              ovr;

   assign raw_in = {frame_i, bit_clk_i, ser_data_i};

   for (genvar s = 0; s < NSYNC; s++) begin : g_sync
      level_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (raw_in[s]),
         .q_o   (lvl[s])
      );
   end

   sample_shifter #(
      .WORD_W    (WORD_W),
      .STAGE_W   (STAGE_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .bclk_lvl (lvl[1]),
      .data_lvl (lvl[0]),
      .word_o   (chain_word)
   );

   hold_ctrl #(.WORD_W(WORD_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_lvl (lvl[2]),
      .rd_i      (rd_i),
      .word_i    (chain_word),
      .hold_o    (hold_word),
      .ready_o   (ready),
      .ovr_o     (ovr)
   );

   assign rdata_o = rd_i ? hold_word : '0;

   always_comb begin
      status_o               = '0;
      status_o[STAT_READY_BIT] = ready;
      status_o[STAT_OVR_BIT]   = ovr;
   end

   // R5: an idle read port drives zero
   a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/adc_capture_port_bench.sv
`timescale 1ns/1ps
module adc_capture_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_data = 1'b0;
   logic        bclk = 1'b0;
   logic        frame = 1'b0;
   logic        rd = 1'b0;
   logic [15:0] rdata;
   logic [7:0]  status;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   adc_capture_port u_adc_capture_port (
      .clk(clk), .rst_n(rst_n), .ser_data_i(ser_data), .bit_clk_i(bclk),
      .frame_i(frame), .rd_i(rd), .rdata_o(rdata), .status_o(status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input int high_cyc, input logic wiggle);
      @(negedge clk); ser_data = b; bclk = 1'b0;
      wait_cyc(3);
      bclk = 1'b1;
      wait_cyc(3);
      for (int i = 0; i < high_cyc; i++) begin
         if (wiggle) ser_data = ~ser_data;
         @(negedge clk);
      end
      bclk = 1'b0;
      wait_cyc(3);
   endtask

   task automatic send_bits(input logic [31:0] w, input int n, input int high_cyc, input logic wiggle);
      for (int i = n-1; i >= 0; i--) send_bit(w[i], high_cyc, wiggle);
   endtask

   task automatic pulse_frame();
      @(negedge clk); frame = 1'b1;
      wait_cyc(4);
      frame = 1'b0;
      wait_cyc(4);
   endtask

   task automatic do_read(input string req, input logic [15:0] exp);
      @(negedge clk); rd = 1'b1;
      #1 chk(req, rdata, exp);
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 status after reset", status, 8'h00);
      chk("R1 idle data after reset", rdata, 16'h0000);
      do_read("R1 read after reset", 16'h0000);
   endtask

   task automatic t_basic(input logic [15:0] w);
      send_bits(w, 16, 0, 1'b0);
      chk("R3 no transfer before frame", status, 8'h00);
      pulse_frame();
      chk("R4 ready after transfer", status, 8'h01);
      chk("R5 data zero while not reading", rdata, 16'h0000);
      do_read("R2 R3 MSB-first word", w);
      wait_cyc(1);
      chk("R6 read clears ready", status, 8'h00);
   endtask

   task automatic t_overrun();
      send_bits(32'h1234, 16, 0, 1'b0);
      pulse_frame();
      send_bits(32'hBEEF, 16, 0, 1'b0);
      pulse_frame();
      chk("R7 overrun and ready", status, 8'h03);
      do_read("R7 newest word kept", 16'hBEEF);
      wait_cyc(1);
      chk("R6 read clears overrun", status, 8'h00);
   endtask

   task automatic t_read_mid_shift();
      send_bits(32'h0F0F, 16, 0, 1'b0);
      pulse_frame();
      send_bits(32'hFF, 8, 0, 1'b0);
      do_read("R8 read during shifting", 16'h0F0F);
      send_bits(32'hFF, 8, 0, 1'b0);
      pulse_frame();
      do_read("R8 following word intact", 16'hFFFF);
   endtask

   task automatic t_level();
      send_bits(32'h6C39, 16, 12, 1'b1);
      pulse_frame();
      do_read("R9 long-high bit clock", 16'h6C39);
   endtask

   task automatic t_long_frame();
      send_bits(32'hABCDE, 20, 0, 1'b0);
      pulse_frame();
      do_read("R11 last 16 bits kept", 16'hBCDE);
   endtask

   task automatic t_same_cycle();
      send_bits(32'h1111, 16, 0, 1'b0);
      pulse_frame();
      send_bits(32'h2222, 16, 0, 1'b0);
      chk("R10 precondition ready", status, 8'h01);
      @(negedge clk); frame = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); rd = 1'b1;
      #1 chk("R10 read returns old word", rdata, 16'h1111);
      @(negedge clk); rd = 1'b0;
      wait_cyc(3); frame = 1'b0; wait_cyc(4);
      chk("R10 ready kept, no overrun", status, 8'h01);
      do_read("R10 new word held", 16'h2222);
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(2);
      t_reset();
      t_basic(16'hA5C3);
      t_basic(16'h8001);
      t_basic(16'h7FFE);
      t_overrun();
      t_read_mid_shift();
      t_level();
      t_long_frame();
      t_same_cycle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule